// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

This block tracks, for every architectural register, how long ago its most recent producer issued and what kind of operation it was. A consumer instruction presents up to `NSRC` source registers, each tagged with how it will use the value: as an execute operand, as a memory address, or as store data. For each source the block answers whether the value is usable in the current cycle. An overall stall flag goes high when any valid source is not usable.

The latency a consumer must wait depends on both the producer class and the consumer usage. For example, an integer ALU result feeds another execute operation after 1 cycle but feeds a load or store address only after 5. Each register entry holds a down-counter loaded with the largest latency of its producer class, together with the class code. A source is ready once the counter has fallen to the level that matches its own usage. Only one producer may issue per cycle. A new producer to a register replaces whatever was pending there.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset, whether at power-up or mid-run, every register is idle: every valid source reads ready and `stall` is low.
- R2: Usage codes are 0 execute operand, 1 memory address, 2 store data, and 3 is treated as 0. A load (class 0) has latency 3 to an address, 0 to store data and 1 to an execute operand.
- R3: An integer ALU result (class 1) has latency 5 to an address and 1 to every other usage.
- R4: A 32-bit multiply (class 2) has latency 7 to an address and 3 otherwise. A 64-bit multiply (class 3) has latency 7 to an address and 4 otherwise.
- R5: The floating-point classes have one latency for every usage. Class 4 covers move, add, multiply, abs, negate, convert and compare, with latency 4. The other classes are: 5 multiply-add 8, 6 integer-to-FP move 5, 7 FP-to-integer move 1, 8 single divide 24, 9 double divide 32, 10 single square root 28, 11 double square root 40, 12 single reciprocal 12, 13 double reciprocal 20, 14 single reciprocal square root 16, 15 double reciprocal square root 28.
- R6: Consider a producer that issues in cycle t with latency L for a source's usage. The source is not ready in cycles t through t+L-1 and is ready from cycle t+L onward. When L is 0, the source is ready in cycle t itself, the same cycle as the write.
- R7: A producer that writes a register whose counter has not yet expired replaces the old one. Readiness then follows only the new producer, whether that makes the wait shorter or longer.
- R8: A source with its valid bit low reads ready. `stall` is high exactly when some valid source is not ready.
- R9: A write to one register has no effect on the readiness of any other register.
- R10: Once a valid source is ready, it stays ready as long as its register and usage are unchanged and its register is not written again.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A producer issues this cycle |
| wr_reg | input | RW | Destination register of the producer |
| wr_class | input | 4 | Producer class code (R2 to R5) |
| src_valid | input | NSRC | Per-source valid |
| src_reg | input | NSRC*RW | Per-source register index, source i at bits [i*RW +: RW] |
| src_use | input | NSRC*2 | Per-source usage code, source i at bits [i*2 +: 2] |
| src_ready | output | NSRC | Per-source ready |
| stall | output | 1 | Some valid source is not ready |

## Verification
The assertions assume that at most one producer issues per cycle and that register indices lie inside the table. They also assume a consumer holds its register and usage steady while waiting, which is the premise of the hold-ready and hold-not-ready properties. The stimulus drives a single write port and always uses in-range indices. Before each latency sweep it lets the targeted register drain for longer than the largest latency, so every sweep starts from an idle entry. Neighbouring registers and an invalid source are watched alongside, so that any disturbance of them shows up at the ports.

// File: rtl/lat_sb_pkg.sv
// Package: class and usage codes plus the fixed latency table.
// Assumes latencies never exceed MAX_PEAK, which must fit in CW bits.
package lat_sb_pkg;

    localparam int CLS_W    = 4;
    localparam int USE_W    = 2;
    localparam int CW       = 6;
    localparam int MAX_PEAK = 40;

    typedef enum logic [CLS_W-1:0] {
        CLS_LOAD    = 4'd0,
        CLS_ALU     = 4'd1,
        CLS_MUL32   = 4'd2,
        CLS_MUL64   = 4'd3,
        CLS_FP      = 4'd4,
        CLS_FMA     = 4'd5,
        CLS_TOFP    = 4'd6,
        CLS_FROMFP  = 4'd7,
        CLS_DIV_S   = 4'd8,
        CLS_DIV_D   = 4'd9,
        CLS_SQRT_S  = 4'd10,
        CLS_SQRT_D  = 4'd11,
        CLS_RCP_S   = 4'd12,
        CLS_RCP_D   = 4'd13,
        CLS_RSQ_S   = 4'd14,
        CLS_RSQ_D   = 4'd15
    } cls_e;

    typedef enum logic [USE_W-1:0] {
        USE_EXEC   = 2'd0,
        USE_ADDR   = 2'd1,
        USE_STDATA = 2'd2,
        USE_RSVD   = 2'd3
    } use_e;

    // Cycles a consumer with usage use_k waits behind a producer of class cls.
    function automatic logic [CW-1:0] need_of(input logic [CLS_W-1:0] cls,
                                              input logic [USE_W-1:0] use_k);
        logic is_addr;
        logic is_st;
        is_addr = (use_k == USE_ADDR);
        is_st   = (use_k == USE_STDATA);
        case (cls)
            CLS_LOAD:   need_of = is_addr ? CW'(3) : (is_st ? CW'(0) : CW'(1));
            CLS_ALU:    need_of = is_addr ? CW'(5) : CW'(1);
            CLS_MUL32:  need_of = is_addr ? CW'(7) : CW'(3);
            CLS_MUL64:  need_of = is_addr ? CW'(7) : CW'(4);
            CLS_FP:     need_of = CW'(4);
            CLS_FMA:    need_of = CW'(8);
            CLS_TOFP:   need_of = CW'(5);
            CLS_FROMFP: need_of = CW'(1);
            CLS_DIV_S:  need_of = CW'(24);
            CLS_DIV_D:  need_of = CW'(32);
            CLS_SQRT_S: need_of = CW'(28);
            CLS_SQRT_D: need_of = CW'(40);
            CLS_RCP_S:  need_of = CW'(12);
            CLS_RCP_D:  need_of = CW'(20);
            CLS_RSQ_S:  need_of = CW'(16);
            default:    need_of = CW'(28);
        endcase
    endfunction

    // Longest wait any usage sees behind class cls; this is the counter load span.
    function automatic logic [CW-1:0] peak_of(input logic [CLS_W-1:0] cls);
        logic [CW-1:0] a;
        logic [CW-1:0] b;
        logic [CW-1:0] c;
        a = need_of(cls, USE_EXEC);
        b = need_of(cls, USE_ADDR);
        c = need_of(cls, USE_STDATA);
        peak_of = (a > b) ? a : b;
        if (c > peak_of) peak_of = c;
    endfunction

endpackage

// File: rtl/lat_sb_entry.sv
// Module: one register entry of the scoreboard.
// Keeps the class of the newest producer and a down-counter holding the
// cycles still left to that class's peak latency. A write always wins.
// Assumes wr_hit is high only for the addressed entry.
module lat_sb_entry
    import lat_sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CLS_W-1:0] wr_class,
    output logic [CW-1:0]    cnt,
    output logic [CLS_W-1:0] cls
);

    logic [CW-1:0]    cnt_q;
    logic [CLS_W-1:0] cls_q;

    // Load on producer issue, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cls_q <= CLS_LOAD;
        end else if (wr_hit) begin
            cnt_q <= peak_of(wr_class) - CW'(1);
            cls_q <= wr_class;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign cnt = cnt_q;
    assign cls = cls_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_PEAK)); // R6

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_hit) && $past(cnt_q) != '0)
        |-> cnt_q == $past(cnt_q) - CW'(1)); // R6

endmodule

// File: rtl/lat_sb_src.sv
// Module: readiness of one consumer source.
// Selects the entry named by the source, looks up how far the counter must
// fall for this usage, and handles a producer writing the same register in
// the same cycle (only a zero-latency pairing is ready then).
// Assumes src_reg indexes an existing entry.
module lat_sb_src
    import lat_sb_pkg::*;
#(
    parameter int NREG = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        src_valid,
    input  logic [RW-1:0]               src_reg,
    input  logic [USE_W-1:0]            src_use,
    input  logic                        wr_valid,
    input  logic [RW-1:0]               wr_reg,
    input  logic [CLS_W-1:0]            wr_class,
    input  logic [NREG-1:0][CW-1:0]     ent_cnt,
    input  logic [NREG-1:0][CLS_W-1:0]  ent_cls,
    output logic                        ready
);

    logic [CW-1:0]    cnt_sel;
    logic [CLS_W-1:0] cls_sel;
    logic [CW-1:0]    thresh;
    logic [CW-1:0]    need_wr;
    logic             hit;

    // Pick the entry this source reads and derive its ready threshold.
    always_comb begin
        cnt_sel = ent_cnt[src_reg];
        cls_sel = ent_cls[src_reg];
        thresh  = peak_of(cls_sel) - need_of(cls_sel, src_use);
        need_wr = need_of(wr_class, src_use);
        hit     = wr_valid && (wr_reg == src_reg);
    end

    // Ready decision: invalid sources pass, same-cycle writes win, else compare.
    always_comb begin
        if (!src_valid)  ready = 1'b1;
        else if (hit)    ready = (need_wr == '0);
        else             ready = (cnt_sel <= thresh);
    end

    AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_valid && hit && need_wr >= CW'(2))
         && src_valid && $stable(src_reg) && $stable(src_use) && !hit)
        |-> !ready); // R6

endmodule

// File: rtl/lat_scoreboard.sv
// Module: producer-consumer latency scoreboard (top).
// One producer write port, NSRC consumer sources. Each source is ready when
// its register's producer latency for that usage has elapsed; stall is the
// OR of the not-ready valid sources.
// Assumes at most one producer per cycle and in-range register indices.
module lat_scoreboard
    import lat_sb_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NSRC = 3,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [RW-1:0]         wr_reg,
    input  logic [CLS_W-1:0]      wr_class,
    input  logic [NSRC-1:0]       src_valid,
    input  logic [NSRC*RW-1:0]    src_reg,
    input  logic [NSRC*USE_W-1:0] src_use,
    output logic [NSRC-1:0]       src_ready,
    output logic                  stall
);

    logic [NREG-1:0][CW-1:0]    ent_cnt;
    logic [NREG-1:0][CLS_W-1:0] ent_cls;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic hit_g;
        assign hit_g = wr_valid && (wr_reg == RW'(g));
        lat_sb_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit_g),
            .wr_class (wr_class),
            .cnt      (ent_cnt[g]),
            .cls      (ent_cls[g])
        );
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [RW-1:0]    reg_i;
        logic [USE_W-1:0] use_i;
        assign reg_i = src_reg[i*RW +: RW];
        assign use_i = src_use[i*USE_W +: USE_W];

        lat_sb_src #(.NREG(NREG), .RW(RW)) u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_valid (src_valid[i]),
            .src_reg   (reg_i),
            .src_use   (use_i),
            .wr_valid  (wr_valid),
            .wr_reg    (wr_reg),
            .wr_class  (wr_class),
            .ent_cnt   (ent_cnt),
            .ent_cls   (ent_cls),
            .ready     (src_ready[i])
        );

        AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(src_valid[i] && src_ready[i]) && src_valid[i]
             && $stable(reg_i) && $stable(use_i)
             && !$past(wr_valid && wr_reg == reg_i)
             && !(wr_valid && wr_reg == reg_i))
            |-> src_ready[i]); // R10
    end

    // Overall stall: any valid source still waiting.
    always_comb begin
        stall = |(src_valid & ~src_ready);
    end

    AST_STALL_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (src_valid != '0)); // R8

endmodule

// File: tb/lat_scoreboard_tb.sv
module lat_scoreboard_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int NSRC = 3;
    localparam int RW   = 4;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 wr_valid;
    logic [RW-1:0]        wr_reg;
    logic [3:0]           wr_class;
    logic [NSRC-1:0]      src_valid;
    logic [NSRC*RW-1:0]   src_reg;
    logic [NSRC*2-1:0]    src_use;
    logic [NSRC-1:0]      src_ready;
    logic                 stall;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_scoreboard #(.NREG(NREG), .NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_reg(wr_reg),
        .wr_class(wr_class), .src_valid(src_valid), .src_reg(src_reg),
        .src_use(src_use), .src_ready(src_ready), .stall(stall)
    );

    // Expected latency, written from the requirement text.
    function automatic int exp_lat(input int c, input int u);
        int uu;
        uu = (u == 3) ? 0 : u;
        case (c)
            0: return (uu == 1) ? 3 : ((uu == 2) ? 0 : 1);
            1: return (uu == 1) ? 5 : 1;
            2: return (uu == 1) ? 7 : 3;
            3: return (uu == 1) ? 7 : 4;
            4: return 4;   5: return 8;   6: return 5;   7: return 1;
            8: return 24;  9: return 32;  10: return 28; 11: return 40;
            12: return 12; 13: return 20; 14: return 16; default: return 28;
        endcase
    endfunction

    function automatic string tag_of(input int c);
        if (c == 0) return "R2";
        if (c == 1) return "R3";
        if (c <= 3) return "R4";
        return "R5";
    endfunction

    task automatic check(input logic act, input logic expv, input string tag, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic set_src(input int i, input logic v, input int r, input int u);
        src_valid[i] = v;
        src_reg[i*RW +: RW] = RW'(r);
        src_use[i*2 +: 2] = 2'(u);
    endtask

    task automatic idle_inputs();
        wr_valid = 1'b0; wr_reg = '0; wr_class = '0;
        src_valid = '0; src_reg = '0; src_use = '0;
    endtask

    // After any reset every register reads ready for an address use (R1).
    task automatic check_all_idle(input string what);
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            set_src(0, 1'b1, r, 1);
            set_src(1, 1'b1, r, 0);
            #1;
            check(src_ready[0], 1'b1, "R1", what);
            check(stall, 1'b0, "R1", what);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all_idle("power-up idle");

        // Exhaustive sweep: every class, every usage, every cycle offset (R2-R6, R8, R9).
        for (int c = 0; c < 16; c++) begin
            for (int u = 0; u < 4; u++) begin
                int r;
                int lat;
                r = (c * 4 + u) % NREG;
                lat = exp_lat(c, u);
                @(negedge clk);
                wr_valid = 1'b1; wr_reg = RW'(r); wr_class = 4'(c);
                set_src(0, 1'b1, r, u);
                set_src(1, 1'b1, (r + 1) % NREG, 1);
                set_src(2, 1'b0, r, u);
                for (int k = 0; k <= 42; k++) begin
                    if (k > 0) begin
                        @(negedge clk);
                        wr_valid = 1'b0;
                    end
                    #1;
                    check(src_ready[0], (k >= lat), tag_of(c), $sformatf("R6 class %0d use %0d k=%0d", c, u, k));
                    check(src_ready[1], 1'b1, "R9", $sformatf("neighbour class %0d k=%0d", c, k));
                    check(src_ready[2], 1'b1, "R8", "invalid source");
                    check(stall, (k < lat), "R8", $sformatf("stall class %0d use %0d k=%0d", c, u, k));
                end
            end
        end

        // R7 shorter: long divide overwritten by an ALU op, execute use.
        idle_inputs();
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd3; wr_class = 4'd9;
        set_src(0, 1'b1, 3, 0);
        repeat (3) begin @(negedge clk); wr_valid = 1'b0; end
        wr_valid = 1'b1; wr_reg = 4'd3; wr_class = 4'd1;
        #1; check(src_ready[0], 1'b0, "R7", "rewrite same cycle");
        @(negedge clk); wr_valid = 1'b0;
        #1; check(src_ready[0], 1'b1, "R7", "shorter producer wins");

        // R7 longer: ALU op overwritten by double square root.
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd4; wr_class = 4'd1;
        set_src(0, 1'b1, 4, 0);
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd4; wr_class = 4'd11;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk); wr_valid = 1'b0;
            #1; check(src_ready[0], (k >= 40), "R7", $sformatf("longer producer k=%0d", k));
        end

        // R6/R7: zero-latency pairing over a pending divide is ready at once.
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd6; wr_class = 4'd8;
        set_src(0, 1'b0, 6, 2);
        repeat (2) begin @(negedge clk); wr_valid = 1'b0; end
        wr_valid = 1'b1; wr_reg = 4'd6; wr_class = 4'd0;
        set_src(0, 1'b1, 6, 2);
        #1; check(src_ready[0], 1'b1, "R6", "load to store data same cycle");
        set_src(0, 1'b1, 6, 1);
        #1; check(src_ready[0], 1'b0, "R6", "load to address same cycle");

        // R1 mid-run reset clears a pending long producer.
        @(negedge clk);
        wr_valid = 1'b1; wr_reg = 4'd7; wr_class = 4'd11;
        @(negedge clk); wr_valid = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        check_all_idle("idle after mid-run reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule